// File: doc/BRIEF.md
# NAND Chunk ECC Checker and Single-Bit Repairer

This block checks one 512-byte NAND data chunk against its 24-bit error code. The host presents two codes: the one read from the spare area and the one computed over the data just read. The block XORs the two codes into a 24-bit syndrome and sorts the outcome into one of three classes: clean, corrected or uncorrectable. A code area that reads as all ones is taken to belong to a page that was never written with a code, so it is reported clean.

When the syndrome shows that exactly one data bit flipped, the block works out the byte address and the bit index of that bit. It then repairs the byte in the host's chunk buffer with a read followed by a write through a simple byte port. When only one syndrome bit is set, the stored code itself is assumed damaged, so the block reports corrected and leaves the buffer alone. A done pulse marks the end of every check, and the status, byte address and bit index stay on the outputs until the next check.

Top module: `nand_ecc_fixer`

## Requirements
- R1: The status output uses 2'b00 for clean, 2'b01 for corrected and 2'b11 for uncorrectable, and never shows 2'b10. After reset it reads 2'b00 and done is low.
- R2: When the stored and computed codes are equal, the status is clean and the buffer port is not accessed.
- R3: When the stored code is 24'hFFFFFF, the status is clean for any computed code, and the buffer is not accessed.
- R4: A syndrome in which every adjacent bit pair (bits 2k+1 and 2k, for k = 0..11) holds exactly one set bit is a data error. Its byte address is {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]}, from MSB to LSB. Its bit index is {s[23], s[21], s[19]}. Both are reported with status corrected.
- R5: For a data error, the addressed byte is read and then written back XORed with 1 << bit index. No other byte changes.
- R6: A syndrome with exactly one bit set gives status corrected, address 0 and bit 0, and the buffer is not accessed.
- R7: Any other nonzero syndrome gives status uncorrectable, and the buffer is not accessed.
- R8: Take the clock edge that samples start as edge 0. Without a repair, done is high in the cycle after edge 0. With a repair, the read strobe is high in that cycle, the write strobe in the next one, and done in the one after that. Done lasts one cycle.
- R9: A start pulse that arrives while a check is still in progress is ignored.
- R10: The read and write strobes are never high in the same cycle. A write always follows a read of the same address in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a check; codes sampled on the same edge |
| stored_ecc_i | input | 24 | Code read from the spare area |
| calc_ecc_i | input | 24 | Code computed over the data |
| buf_addr_o | output | 9 | Chunk buffer byte address |
| buf_rd_o | output | 1 | Buffer read strobe; data expected the next cycle |
| buf_rdata_i | input | 8 | Buffer read data |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Check outcome |
| err_addr_o | output | 9 | Byte address of the repaired bit |
| err_bit_o | output | 3 | Bit index of the repaired bit |

## Verification
The bench uses the default widths: a 9-bit byte address and 8-bit data. With these, every one of the 512 byte positions and 8 bit positions can be reached by building the syndrome from a chosen address and bit. Directed cases cover the lowest and highest addresses, a blank code area with a non-matching computed code, each lone syndrome bit, and a start that arrives mid-repair. Random codes then mix all outcome classes, and after every check the whole buffer model is compared with its expected contents.

// File: rtl/nfecc_pkg.sv
package nfecc_pkg;
  localparam int BYTE_W     = 8;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = BYTE_W * CODE_BYTES;
  localparam int PAIRS      = CODE_W / 2;
  localparam int ADDR_W     = 9;
  localparam int BIT_W      = 3;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FAIL  = 2'b11
  } status_t;
endpackage

// File: rtl/nfecc_locate.sv
module nfecc_locate
  import nfecc_pkg::*;
(
  input  logic [PAIRS-1:0]  odd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BIT_W-1:0]  bit_o
);
  // odd_i[k] is syndrome bit 2k+1
  localparam int NIB = BYTE_W / 2;

  for (genvar k = 0; k < NIB; k++) begin : g_lo
    assign addr_o[k]       = odd_i[k];
    assign addr_o[NIB + k] = odd_i[NIB + k];
  end
  assign addr_o[ADDR_W-1] = odd_i[2*NIB];

  for (genvar j = 0; j < BIT_W; j++) begin : g_bit
    assign bit_o[j] = odd_i[2*NIB + 1 + j];
  end
endmodule

// File: rtl/nfecc_classify.sv
module nfecc_classify
  import nfecc_pkg::*;
(
  input  logic [CODE_W-1:0] stored_i,
  input  logic [CODE_W-1:0] calc_i,
  output status_t           verdict_o,
  output logic              repair_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BIT_W-1:0]  bit_o
);
  logic [CODE_W-1:0] syn;
  logic [PAIRS-1:0]  pair_ok;
  logic [PAIRS-1:0]  odd_bits;
  logic              blank;
  logic              lone_bit;
  logic              data_err;
  logic [ADDR_W-1:0] loc_addr;
  logic [BIT_W-1:0]  loc_bit;

  assign syn = stored_i ^ calc_i;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_ok[p]  = syn[2*p] ^ syn[2*p+1];
    assign odd_bits[p] = syn[2*p+1];
  end

  assign blank    = &stored_i;
  assign data_err = &pair_ok;
  assign lone_bit = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  nfecc_locate u_locate (
    .odd_i  (odd_bits),
    .addr_o (loc_addr),
    .bit_o  (loc_bit)
  );

  always_comb begin
    verdict_o = ST_FAIL;
    repair_o  = 1'b0;
    addr_o    = '0;
    bit_o     = '0;
    if (syn == '0 || blank) begin
      verdict_o = ST_CLEAN;
    end else if (data_err) begin
      verdict_o = ST_FIXED;
      repair_o  = 1'b1;
      addr_o    = loc_addr;
      bit_o     = loc_bit;
    end else if (lone_bit) begin
      verdict_o = ST_FIXED;
    end
  end
endmodule

// File: rtl/nfecc_seq.sv
module nfecc_seq
  import nfecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  status_t           verdict_i,
  input  logic              repair_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              done_o,
  output status_t           status_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BIT_W-1:0]  bit_o
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_FIN} seq_t;

  seq_t              state_q, state_d;
  status_t           status_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              cap_en;

  assign cap_en = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = repair_i ? S_READ : S_FIN;
      S_READ:  state_d = S_WRITE;
      S_WRITE: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_CLEAN;
      addr_q   <= '0;
      bit_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        status_q <= verdict_i;
        addr_q   <= addr_i;
        bit_q    <= bit_i;
      end
    end
  end

  assign rd_o     = (state_q == S_READ);
  assign wr_o     = (state_q == S_WRITE);
  assign wdata_o  = rdata_i ^ (BYTE_W'(1) << bit_q);
  assign done_o   = (state_q == S_FIN);
  assign status_o = status_q;
  assign addr_o   = addr_q;
  assign bit_o    = bit_q;
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import nfecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] stored_ecc_i,
  input  logic [CODE_W-1:0] calc_ecc_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_rd_o,
  input  logic [BYTE_W-1:0] buf_rdata_i,
  output logic              buf_wr_o,
  output logic [BYTE_W-1:0] buf_wdata_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [BIT_W-1:0]  err_bit_o
);
  status_t           verdict;
  status_t           status_q;
  logic              repair;
  logic [ADDR_W-1:0] cls_addr;
  logic [BIT_W-1:0]  cls_bit;
  logic [ADDR_W-1:0] held_addr;

  nfecc_classify u_classify (
    .stored_i  (stored_ecc_i),
    .calc_i    (calc_ecc_i),
    .verdict_o (verdict),
    .repair_o  (repair),
    .addr_o    (cls_addr),
    .bit_o     (cls_bit)
  );

  nfecc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .verdict_i (verdict),
    .repair_i  (repair),
    .addr_i    (cls_addr),
    .bit_i     (cls_bit),
    .rdata_i   (buf_rdata_i),
    .rd_o      (buf_rd_o),
    .wr_o      (buf_wr_o),
    .wdata_o   (buf_wdata_o),
    .done_o    (done_o),
    .status_o  (status_q),
    .addr_o    (held_addr),
    .bit_o     (err_bit_o)
  );

  assign status_o   = status_q;
  assign buf_addr_o = held_addr;
  assign err_addr_o = held_addr;
endmodule

// File: rtl/nand_ecc_fixer_chk.sv
module nand_ecc_fixer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] buf_addr_o,
  input logic       buf_rd_o,
  input logic       buf_wr_o,
  input logic       done_o,
  input logic [1:0] status_o
);
  a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'b10);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_o && buf_wr_o));

  a_r10_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_o |-> $past(buf_rd_o) && buf_addr_o == $past(buf_addr_o));

  a_r5_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_o |=> done_o && status_o == 2'b01);

  a_r7_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != 2'b01) |-> !$past(buf_wr_o));
endmodule

bind nand_ecc_fixer nand_ecc_fixer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .buf_addr_o (buf_addr_o),
  .buf_rd_o   (buf_rd_o),
  .buf_wr_o   (buf_wr_o),
  .done_o     (done_o),
  .status_o   (status_o)
);

// File: tb/nand_ecc_fixer_tb.sv
`timescale 1ns/1ps
module nand_ecc_fixer_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] stored_ecc_i;
  logic [23:0] calc_ecc_i;
  logic [8:0]  buf_addr_o;
  logic        buf_rd_o;
  logic [7:0]  buf_rdata_i;
  logic        buf_wr_o;
  logic [7:0]  buf_wdata_o;
  logic        done_o;
  logic [1:0]  status_o;
  logic [8:0]  err_addr_o;
  logic [2:0]  err_bit_o;

  int n_chk;
  int n_fail;
  int acc_cnt;
  int cyc;

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];

  nand_ecc_fixer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .stored_ecc_i(stored_ecc_i), .calc_ecc_i(calc_ecc_i),
    .buf_addr_o(buf_addr_o), .buf_rd_o(buf_rd_o), .buf_rdata_i(buf_rdata_i),
    .buf_wr_o(buf_wr_o), .buf_wdata_o(buf_wdata_o), .done_o(done_o),
    .status_o(status_o), .err_addr_o(err_addr_o), .err_bit_o(err_bit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // synchronous-read buffer model
  always @(posedge clk) begin
    if (buf_rd_o) buf_rdata_i <= mem[buf_addr_o];
    if (buf_wr_o) mem[buf_addr_o] <= buf_wdata_o;
    if (buf_rd_o || buf_wr_o) acc_cnt <= acc_cnt + 1;
    cyc <= cyc + 1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual cyc=%0d expected <150000)", cyc);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] make_syn(input logic [8:0] a, input logic [2:0] b);
    logic [23:0] s;
    logic [11:0] odd;
    odd = {b, a};
    for (int k = 0; k < 12; k++) begin
      s[2*k+1] = odd[k];
      s[2*k]   = ~odd[k];
    end
    return s;
  endfunction

  function automatic void model(input logic [23:0] st, input logic [23:0] ca,
                                output logic [1:0] sts, output logic fix,
                                output logic [8:0] a, output logic [2:0] b);
    logic [23:0] s;
    logic paired;
    int ones;
    s = st ^ ca;
    fix = 1'b0; a = '0; b = '0;
    paired = 1'b1;
    ones = 0;
    for (int k = 0; k < 12; k++) if (s[2*k] == s[2*k+1]) paired = 1'b0;
    for (int k = 0; k < 24; k++) if (s[k]) ones++;
    if (s == 0 || st == 24'hFFFFFF) sts = 2'b00;
    else if (paired) begin
      sts = 2'b01; fix = 1'b1;
      a = {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]};
      b = {s[23], s[21], s[19]};
    end else if (ones == 1) sts = 2'b01;
    else sts = 2'b11;
  endfunction

  task automatic run(input logic [23:0] st, input logic [23:0] ca, input bit busy_poke);
    logic [1:0] es; logic ef; logic [8:0] ea; logic [2:0] eb;
    int lat;
    int mism;
    model(st, ca, es, ef, ea, eb);
    @(negedge clk);
    acc_cnt = 0;
    start_i = 1'b1; stored_ecc_i = st; calc_ecc_i = ca;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    if (busy_poke) begin
      start_i = 1'b1; stored_ecc_i = 24'h123456; calc_ecc_i = 24'h654321;
    end
    while (!done_o && lat < 10) begin
      if (ef && lat == 1) check("R8 read strobe cycle", buf_rd_o, 1'b1);
      if (ef && lat == 2) check("R8 write strobe cycle", buf_wr_o, 1'b1);
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end
    start_i = 1'b0;
    check("R8 done latency", lat, ef ? 3 : 1);
    check("R1 status", status_o, es);
    if (es == 2'b01) begin
      check("R4 error address", err_addr_o, ea);
      check("R4 error bit", err_bit_o, eb);
    end
    check(ef ? "R5 buffer accesses" : "R7 R2 R3 R6 no buffer access", acc_cnt, ef ? 2 : 0);
    if (ef) exp_mem[ea] = exp_mem[ea] ^ (8'd1 << eb);
    @(negedge clk);
    check("R8 done one cycle", done_o, 1'b0);
    if (busy_poke) begin
      @(negedge clk);
      check("R9 late start ignored", {30'd0, done_o, buf_rd_o}, 0);
    end
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) mism++;
    check("R5 buffer contents", mism, 0);
  endtask

  initial begin
    logic [23:0] st;
    void'($urandom(32'd2024));
    n_chk = 0; n_fail = 0; acc_cnt = 0; cyc = 0;
    start_i = 0; stored_ecc_i = 0; calc_ecc_i = 0;
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset status", status_o, 2'b00);
    check("R1 reset done", done_o, 1'b0);
    check("R10 reset strobes", {buf_rd_o, buf_wr_o}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    run(24'h3A5C71, 24'h3A5C71, 0);                       // R2
    run(24'hFFFFFF, 24'h00F00F, 0);                       // R3
    run(24'hFFFFFF, 24'hFFFFFF ^ make_syn(9'd7, 3'd2), 0); // R3 blank beats fix
    run(24'h102030, 24'h102030 ^ make_syn(9'd0, 3'd0), 0);   // R4 R5 low corner
    run(24'h0A0B0C, 24'h0A0B0C ^ make_syn(9'd511, 3'd7), 0); // R4 R5 high corner
    run(24'h445566, 24'h445566 ^ make_syn(9'd300, 3'd5), 1); // R9
    for (int k = 0; k < 24; k++) run(24'h1C2D3E, 24'h1C2D3E ^ (24'd1 << k), 0); // R6
    run(24'h000000, 24'h000003, 0);                       // R7
    run(24'h555555, 24'hAAAAA0, 0);                       // R7

    for (int n = 0; n < 300; n++) begin
      int kind;
      kind = int'($urandom % 4);
      st = 24'($urandom);
      if (st == 24'hFFFFFF) st[0] = 1'b0;
      case (kind)
        0: run(st, st, 0);
        1: run(st, st ^ make_syn(9'($urandom), 3'($urandom)), 0);
        2: run(st, st ^ (24'd1 << ($urandom % 24)), 0);
        default: run(st, 24'($urandom), n % 17 == 0);
      endcase
    end
    summary();
  end
endmodule